// File: doc/BRIEF.md
# Configurable Interrupt Aggregator

The aggregator gathers up to 24 interrupt lines from peripherals into one interrupt request for the processor. Each line is first passed through a two-stage synchroniser. It is then qualified by its own sense bit, which selects active-high or active-low. Its own mode bit selects level or edge detection. A detected event sets a sticky pending bit. The request output is asserted while any pending bit is set that is not masked.

Software reaches the four 24-bit banks through a byte-wide write port and a combinational read port. The banks are pending, sense, mode and mask. Each bank is split into three byte lanes. Pending bits are cleared by writing ones to them. The set of lines that are wired is a parameter, and positions that are not wired stay at zero in every bank.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the pending, sense and mode banks read zero, and the mask bank reads all wired bits as one: byte 0 = 0xBF, byte 1 = 0xF1, byte 2 = 0x0F. `irq_o` is low.
- R2: `addr_i[3:2]` selects the bank (0 pending, 1 sense, 2 mode, 3 mask) and `addr_i[1:0]` selects the byte lane (lane k holds source bits 8k..8k+7). Lane 3 reads 0x00. The sense, mode and mask banks read back the wired bits of the last value written.
- R3: The wired positions are byte 0 bits 0-5 and 7, byte 1 bits 0 and 4-7, and byte 2 bits 0-3. Every other position reads zero in every bank and never becomes pending, whatever its input does.
- R4: Each source passes through two synchroniser flops. A change that is driven before rising edge 1 sets pending at rising edge 3, and has not set it after edge 2.
- R5: In level mode (mode bit 0), pending is set on every cycle in which the synchronised input is active. Sense bit 0 means active-high and sense bit 1 means active-low.
- R6: In edge mode (mode bit 1), pending is set only on a change from inactive to active. An input that stays active, or that goes inactive, does not set it again.
- R7: Writing 1 to a pending bit clears it and writing 0 leaves it unchanged. If an event occurs in the same cycle as the clear, the bit stays set.
- R8: `irq_o` is high exactly when some pending bit has its mask bit at 0. A mask bit of 1 blocks that source from `irq_o`, but its pending bit is still recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 24 | Raw interrupt source lines |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Bank (bits 3:2) and byte lane (bits 1:0) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the addressed byte |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions check several rules on every cycle, for every bit:
- a pending bit rises only when its synchronised input was active, and in edge mode only when that input was previously inactive;
- a set pending bit falls only under a write-one clear;
- the request stays low while every wired source is masked.

Only the bench scenarios can show the rest:
- the exact three-edge latency;
- the effect of inverted sense;
- the clear-versus-event race;
- the readback values and reset values of each lane;
- the zeroed unwired positions.

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int NBYTES = 3,
  parameter logic [8*NBYTES-1:0] WIRED = 24'h0F_F1_BF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [8*NBYTES-1:0] src_i,
  input  logic              wr_en_i,
  input  logic [3:0]        addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              irq_o
);
  localparam int N = 8 * NBYTES;

  logic [N-1:0] sy1_q, sy2_q, prev_q;
  logic [N-1:0] pend_q, sense_q, mode_q, mask_q;
  logic [N-1:0] act, evt, wbits, wlane, clr;
  logic [4:0]   shamt;
  logic [N-1:0] rbank;
  logic [31:0]  rpad;

  assign shamt = {addr_i[1:0], 3'b000};
  assign wbits = N'(wdata_i) << shamt;
  assign wlane = N'(8'hFF) << shamt;
  assign clr   = (wr_en_i && addr_i[3:2] == 2'd0) ? wbits : '0;

  assign act = sy2_q ^ sense_q;
  assign evt = act & (~mode_q | ~prev_q) & WIRED;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1_q   <= '0;
      sy2_q   <= '0;
      prev_q  <= '0;
      pend_q  <= '0;
      sense_q <= '0;
      mode_q  <= '0;
      mask_q  <= WIRED;
    end else begin
      sy1_q  <= src_i;
      sy2_q  <= sy1_q;
      prev_q <= act;
      pend_q <= ((pend_q & ~clr) | evt) & WIRED;
      if (wr_en_i && addr_i[3:2] == 2'd1) sense_q <= WIRED & ((sense_q & ~wlane) | (wbits & wlane));
      if (wr_en_i && addr_i[3:2] == 2'd2) mode_q  <= WIRED & ((mode_q  & ~wlane) | (wbits & wlane));
      if (wr_en_i && addr_i[3:2] == 2'd3) mask_q  <= WIRED & ((mask_q  & ~wlane) | (wbits & wlane));
    end
  end

  always_comb begin
    case (addr_i[3:2])
      2'd0:    rbank = pend_q;
      2'd1:    rbank = sense_q;
      2'd2:    rbank = mode_q;
      default: rbank = mask_q;
    endcase
  end

  assign rpad    = 32'(rbank);
  assign rdata_o = rpad[shamt +: 8];
  assign irq_o   = |(pend_q & ~mask_q);

  for (genvar i = 0; i < N; i++) begin : g_chk
    p_set_needs_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !pend_q[i] |=> (!pend_q[i] || $past(act[i])));
    p_edge_needs_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend_q[i] && mode_q[i]) |=> (!pend_q[i] || !$past(prev_q[i])));
    p_sticky_until_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[i] && !clr[i]) |=> pend_q[i]);
  end

  p_all_masked_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (&(mask_q | ~WIRED)) |-> !irq_o);
endmodule

// File: tb/irq_aggregator_bench.sv
module irq_aggregator_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] src = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        irq;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 0;

  irq_aggregator u_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .src_i(src), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rdchk(input string tag, input logic [3:0] a, input logic [7:0] exp);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic t_reset;
    for (int b = 0; b < 4; b++) begin
      rdchk("R1 reset lane0", 4'(b*4),   b == 3 ? 8'hBF : 8'h00);
      rdchk("R1 reset lane1", 4'(b*4+1), b == 3 ? 8'hF1 : 8'h00);
      rdchk("R1 reset lane2", 4'(b*4+2), b == 3 ? 8'h0F : 8'h00);
      rdchk("R2 lane3 zero",  4'(b*4+3), 8'h00);
    end
    chk("R1 irq low", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_regs;
    wr(4'h8, 8'hFF); rdchk("R2 R3 mode lane0 readback", 4'h8, 8'hBF);
    wr(4'h8, 8'h00); rdchk("R2 mode lane0 cleared", 4'h8, 8'h00);
    wr(4'hD, 8'h5A); rdchk("R2 R3 mask lane1 readback", 4'hD, 8'h50);
    wr(4'hD, 8'hF1);
    wr(4'h6, 8'hAA); rdchk("R2 R3 sense lane2 readback", 4'h6, 8'h0A);
    wr(4'h6, 8'h00); cyc(4);
    wr(4'h2, 8'hFF); cyc(1); rdchk("R7 cleanup lane2", 4'h2, 8'h00);
  endtask

  task automatic t_latency;
    @(negedge clk); src[0] = 1'b1;
    cyc(2); rdchk("R4 not yet after two edges", 4'h0, 8'h00);
    cyc(1); rdchk("R4 pending after third edge", 4'h0, 8'h01);
    wr(4'h0, 8'h00); rdchk("R7 write zero keeps", 4'h0, 8'h01);
    wr(4'h0, 8'h01); rdchk("R7 event wins over clear", 4'h0, 8'h01);
    src[0] = 1'b0; cyc(4);
    wr(4'h0, 8'h01); rdchk("R7 clear with input idle", 4'h0, 8'h00);
  endtask

  task automatic t_sense;
    wr(4'h4, 8'h04); cyc(4);
    rdchk("R5 active-low sense sets", 4'h0, 8'h04);
    src[2] = 1'b1; cyc(4);
    wr(4'h0, 8'h04); cyc(3);
    rdchk("R5 high input inactive when inverted", 4'h0, 8'h00);
    wr(4'h4, 8'h00); cyc(3);
    rdchk("R5 level active-high sets", 4'h0, 8'h04);
    src[2] = 1'b0; cyc(4);
    wr(4'h0, 8'h04); rdchk("R5 cleanup", 4'h0, 8'h00);
  endtask

  task automatic t_edge;
    wr(4'h9, 8'h01);
    src[8] = 1'b1; cyc(4);
    rdchk("R6 rising edge sets", 4'h1, 8'h01);
    wr(4'h1, 8'h01); cyc(4);
    rdchk("R6 held high no retrigger", 4'h1, 8'h00);
    src[8] = 1'b0; cyc(4);
    rdchk("R6 falling no event", 4'h1, 8'h00);
    src[8] = 1'b1; cyc(4);
    rdchk("R6 second rise sets", 4'h1, 8'h01);
    src[8] = 1'b0; cyc(4);
    wr(4'h1, 8'h01); wr(4'h9, 8'h00);
  endtask

  task automatic t_mask;
    src[15] = 1'b1; cyc(4);
    rdchk("R8 masked still records", 4'h1, 8'h80);
    chk("R8 masked irq low", {7'b0, irq}, 8'h00);
    wr(4'hD, 8'h71);
    chk("R8 unmasked irq high", {7'b0, irq}, 8'h01);
    wr(4'hD, 8'hF1);
    chk("R8 remasked irq low", {7'b0, irq}, 8'h00);
    src[15] = 1'b0; cyc(4);
    wr(4'h1, 8'h80);
  endtask

  task automatic t_unwired;
    wr(4'hC, 8'h00); wr(4'hD, 8'h00); wr(4'hE, 8'h00);
    src[6] = 1'b1; src[11:9] = 3'b111; src[23:20] = 4'hF;
    cyc(5);
    rdchk("R3 lane0 unwired", 4'h0, 8'h00);
    rdchk("R3 lane1 unwired", 4'h1, 8'h00);
    rdchk("R3 lane2 unwired", 4'h2, 8'h00);
    chk("R3 unwired no irq", {7'b0, irq}, 8'h00);
    src = '0;
    wr(4'hC, 8'hFF); wr(4'hD, 8'hFF); wr(4'hE, 8'hFF);
  endtask

  function automatic void summary;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endfunction

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_regs();
    t_latency();
    t_sense();
    t_edge();
    t_mask();
    t_unwired();
    done = 1;
    summary();
    $finish;
  end
endmodule